// File: doc/BRIEF.md
# Byte-Addressed Register Bank with Index Window

This block is the register side of a byte-serial target port. A bus engine in front of it hands over a start-of-transfer register address, then a stream of byte writes or byte read requests. The bank keeps a running register pointer, applies each location's access rule, and returns read bytes one cycle after each request. The access rules are read-only, write-only, read-write and not present.

After most bytes the pointer moves on by one, so a burst walks through neighbouring registers. A small set of window registers keeps the pointer where it is. One of them is an index register into a 200-byte scratch memory. Another is a data port that reads or writes the scratch byte at that index and then steps the index, so a burst on the port streams through the memory. A power-control byte keeps only its low nibble, and that nibble is driven out on a port.

Top module: `byte_reg_window`

## Requirements
- R1: After each byte read or written at a register that is not a window register, the register pointer advances by one, wrapping from 0xFF to 0x00.
- R2: The window registers 0x29, 0x2D, 0x4F, 0x60, 0x61 and 0x7F keep the pointer unchanged during a burst. Repeated writes to 0x29 land on 0x29, and register 0x2A is left untouched.
- R3: Register 0x60 holds the scratch index and reads back its value. A written value from 0 to 199 is taken as is, and a written value of 200 or more loads 0.
- R4: Each byte read or written at register 0x61 accesses the scratch byte at the current index, then steps the index by one, going from 199 to 0. The index persists across transfers until it is rewritten.
- R5: Registers 0x00 and 0x01 read the version constants 0x12 and 0x34. Registers 0x08–0x14, 0x45–0x4A, 0x4F and 0x7F read 0x00. Writes to any of these have no effect.
- R6: Write-only registers 0x20–0x23 and 0x2D read 0x00.
- R7: Addresses 0x5B–0x5F, 0x62–0x7E and 0x80–0xFF read 0xFF and ignore writes.
- R8: Register 0x20 stores only bits 3:0 of a written byte, and `pwr_o` shows those four bits.
- R9: A start replaces the running pointer with `addr_i`. A byte write or read in the same cycle as the start acts on `addr_i`.
- R10: When `wr_i` and `rd_i` are both high in one cycle, the write is performed and the read is dropped, so `rvalid_o` stays low in the next cycle.
- R11: `rdata_o` and `rvalid_o` are registered and appear in the cycle after the read request. `rvalid_o` is low in any cycle that follows no read.
- R12: A synchronous reset clears every storage byte, the scratch index and the pointer to zero. All other read-write registers store the full byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start of transfer; load pointer from `addr_i` |
| addr_i | input | 8 | Register address carried with a start |
| wr_i | input | 1 | Write one byte at the current address |
| wdata_i | input | 8 | Write data byte |
| rd_i | input | 1 | Request one read byte at the current address |
| rdata_o | output | 8 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_i` |
| pwr_o | output | 4 | Stored power-control nibble |

## Verification
Two events can coincide in a single cycle. A start can arrive together with a byte operation, and a write can arrive together with a read. The bench raises `start_i` and `wr_i` together, then follows with a plain write, and expects the first byte at the new address and the second at the address after it. It also raises `wr_i` and `rd_i` together on a read-write register, checks that `rvalid_o` stays low in the next cycle, and then reads the register back to confirm the write was stored.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

  typedef enum logic [2:0] {
    ATTR_NONE     = 3'd0,
    ATTR_RO_CONST = 3'd1,
    ATTR_RO       = 3'd2,
    ATTR_WO       = 3'd3,
    ATTR_RW       = 3'd4
  } attr_e;

  localparam logic [7:0] ADR_PWR  = 8'h20;
  localparam logic [7:0] ADR_IDX  = 8'h60;
  localparam logic [7:0] ADR_PORT = 8'h61;

  function automatic attr_e attr_of(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h01)
      return ATTR_RO_CONST;
    else if ((a >= 8'h08 && a <= 8'h14) || (a >= 8'h45 && a <= 8'h4A) ||
             a == 8'h4F || a == 8'h7F)
      return ATTR_RO;
    else if ((a >= 8'h20 && a <= 8'h23) || a == 8'h2D)
      return ATTR_WO;
    else if (a <= 8'h5A || a == ADR_IDX || a == ADR_PORT)
      return ATTR_RW;
    else
      return ATTR_NONE;
  endfunction

  function automatic logic hold_of(input logic [7:0] a);
    return (a == 8'h29) || (a == 8'h2D) || (a == 8'h4F) ||
           (a == ADR_IDX) || (a == ADR_PORT) || (a == 8'h7F);
  endfunction

endpackage

// File: rtl/rbw_decode.sv
module rbw_decode
  import rbw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  output attr_e         attr,
  output logic          hold
);
  always_comb begin
    attr = attr_of(addr);
    hold = hold_of(addr);
  end

  always_comb begin
    // R2 / R7: a location that does not exist is never a window register
    if (attr == ATTR_NONE) assert (!hold);
  end
endmodule

// File: rtl/rbw_regfile.sv
module rbw_regfile
  import rbw_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] pwr_byte
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata    = mem[addr];
  assign pwr_byte = mem[ADR_PWR[AW-1:0]];
endmodule

// File: rtl/rbw_scratch.sv
module rbw_scratch #(
  parameter int DW     = 8,
  parameter int DEPTH  = 200,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_load,
  input  logic [DW-1:0] idx_val,
  input  logic          port_wr,
  input  logic          port_rd,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nx;

  always_comb begin
    idx_nx = (idx_q == IW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (port_wr) mem[idx_q] <= wdata;
      if (idx_load)
        idx_q <= (int'(idx_val) >= DEPTH) ? '0 : IW'(idx_val);
      else if (port_wr || port_rd)
        idx_q <= idx_nx;
    end
  end

  assign idx_o = idx_q;
  assign rdata = mem[idx_q];

  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) < DEPTH);

  a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
    (!idx_load && (port_wr || port_rd)) |=>
      (idx_q == (($past(idx_q) == IW'(DEPTH - 1)) ? '0 : $past(idx_q) + 1'b1)));

  a_r4_idx_keep: assert property (@(posedge clk) disable iff (rst)
    (!idx_load && !port_wr && !port_rd) |=> $stable(idx_q));
endmodule

// File: rtl/byte_reg_window.sv
module byte_reg_window
  import rbw_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          AW        = 8,
  parameter int          RF_DEPTH  = 128,
  parameter int          SCR_DEPTH = 200,
  parameter int          PWR_W     = 4,
  parameter logic [7:0]  VER_HI    = 8'h12,
  parameter logic [7:0]  VER_LO    = 8'h34,
  parameter logic [7:0]  WO_FILL   = 8'h00,
  parameter logic [7:0]  NONE_FILL = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic [PWR_W-1:0] pwr_o
);
  localparam int RF_AW = $clog2(RF_DEPTH);
  localparam int IW    = $clog2(SCR_DEPTH);
  localparam logic [DW-1:0] PWR_MASK = DW'((1 << PWR_W) - 1);

  logic [AW-1:0] ptr_q, eff;
  attr_e         attr;
  logic          hold;
  logic          op, rd_go, is_idx, is_port, rf_we;
  logic [DW-1:0] rf_wdata, rf_rdata, pwr_byte, scr_rdata, rd_mux;
  logic [IW-1:0] idx;

  assign eff     = start_i ? addr_i : ptr_q;
  assign op      = wr_i || rd_i;
  assign rd_go   = rd_i && !wr_i;
  assign is_idx  = (eff == ADR_IDX);
  assign is_port = (eff == ADR_PORT);
  assign rf_we   = wr_i && ((attr == ATTR_RW && !is_idx && !is_port) || attr == ATTR_WO);
  assign rf_wdata = (eff == ADR_PWR) ? (wdata_i & PWR_MASK) : wdata_i;

  rbw_decode #(.AW(AW)) u_dec (
    .addr (eff),
    .attr (attr),
    .hold (hold)
  );

  rbw_regfile #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .addr     (eff[RF_AW-1:0]),
    .wdata    (rf_wdata),
    .rdata    (rf_rdata),
    .pwr_byte (pwr_byte)
  );

  rbw_scratch #(.DW(DW), .DEPTH(SCR_DEPTH)) u_scr (
    .clk      (clk),
    .rst      (rst),
    .idx_load (wr_i && is_idx),
    .idx_val  (wdata_i),
    .port_wr  (wr_i && is_port),
    .port_rd  (rd_go && is_port),
    .wdata    (wdata_i),
    .idx_o    (idx),
    .rdata    (scr_rdata)
  );

  always_comb begin
    unique case (attr)
      ATTR_NONE:     rd_mux = NONE_FILL;
      ATTR_WO:       rd_mux = WO_FILL;
      ATTR_RO_CONST: rd_mux = eff[0] ? VER_LO : VER_HI;
      ATTR_RO:       rd_mux = '0;
      default: begin
        if (is_idx)       rd_mux = DW'(idx);
        else if (is_port) rd_mux = scr_rdata;
        else              rd_mux = rf_rdata;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (op)           ptr_q <= hold ? eff : eff + 1'b1;
      else if (start_i) ptr_q <= addr_i;
      rvalid_o <= rd_go;
      if (rd_go) rdata_o <= rd_mux;
    end
  end

  assign pwr_o = pwr_byte[PWR_W-1:0];

  always_comb begin
    // R8: bits above the power nibble never survive a write
    if (!rst) assert ((pwr_byte & ~PWR_MASK) == '0);
  end

  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    (op && !start_i && !hold_of(ptr_q)) |=> (ptr_q == $past(ptr_q) + 1'b1));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (op && hold) |=> (ptr_q == $past(eff)));

  a_r9_start_load: assert property (@(posedge clk) disable iff (rst)
    (start_i && !op) |=> (ptr_q == $past(addr_i)));

  a_r10_wr_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_i && rd_i) |=> !rvalid_o);

  a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i) |=> rvalid_o);

  a_r7_none_fill: assert property (@(posedge clk) disable iff (rst)
    (rd_go && attr == ATTR_NONE) |=> (rdata_o == NONE_FILL));
endmodule

// File: tb/test_byte_reg_window.sv
module test_byte_reg_window;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       rvalid_o;
  logic [3:0] pwr_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  byte_reg_window i_byte_reg_window (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .pwr_o(pwr_o)
  );

  // {req[3:0], op[1:0], val[7:0], exp[7:0]}; op 0 start, 1 write, 2 read-check
  localparam int NV = 52;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1, 2'd0, 8'h02, 8'h00}, {4'd1, 2'd1, 8'hA5, 8'h00}, {4'd1, 2'd1, 8'h3C, 8'h00},
    {4'd1, 2'd0, 8'h02, 8'h00}, {4'd1, 2'd2, 8'h00, 8'hA5}, {4'd12, 2'd2, 8'h00, 8'h3C}, // R1 R12
    {4'd5, 2'd0, 8'h00, 8'h00}, {4'd5, 2'd2, 8'h00, 8'h12}, {4'd5, 2'd2, 8'h00, 8'h34},  // R5 version
    {4'd5, 2'd0, 8'h08, 8'h00}, {4'd5, 2'd1, 8'h55, 8'h00}, {4'd5, 2'd0, 8'h08, 8'h00},
    {4'd5, 2'd2, 8'h00, 8'h00},                                                        // R5 write ignored
    {4'd7, 2'd0, 8'h5D, 8'h00}, {4'd7, 2'd1, 8'h77, 8'h00}, {4'd7, 2'd0, 8'h5D, 8'h00},
    {4'd7, 2'd2, 8'h00, 8'hFF}, {4'd7, 2'd0, 8'h90, 8'h00}, {4'd7, 2'd2, 8'h00, 8'hFF},  // R7
    {4'd7, 2'd0, 8'h70, 8'h00}, {4'd7, 2'd2, 8'h00, 8'hFF},
    {4'd6, 2'd0, 8'h20, 8'h00}, {4'd6, 2'd1, 8'hF6, 8'h00}, {4'd6, 2'd0, 8'h20, 8'h00},
    {4'd6, 2'd2, 8'h00, 8'h00},                                                        // R6
    {4'd2, 2'd0, 8'h29, 8'h00}, {4'd2, 2'd1, 8'h11, 8'h00}, {4'd2, 2'd1, 8'h22, 8'h00},
    {4'd2, 2'd0, 8'h29, 8'h00}, {4'd2, 2'd2, 8'h00, 8'h22}, {4'd2, 2'd2, 8'h00, 8'h22},  // R2
    {4'd2, 2'd0, 8'h2A, 8'h00}, {4'd2, 2'd2, 8'h00, 8'h00},
    {4'd4, 2'd0, 8'h60, 8'h00}, {4'd4, 2'd1, 8'hC6, 8'h00}, {4'd4, 2'd0, 8'h61, 8'h00},
    {4'd4, 2'd1, 8'hAA, 8'h00}, {4'd4, 2'd1, 8'hBB, 8'h00}, {4'd4, 2'd1, 8'hCC, 8'h00},
    {4'd4, 2'd0, 8'h60, 8'h00}, {4'd4, 2'd2, 8'h00, 8'h01},                             // R4 wrap
    {4'd4, 2'd1, 8'hC6, 8'h00}, {4'd4, 2'd0, 8'h61, 8'h00}, {4'd4, 2'd2, 8'h00, 8'hAA},
    {4'd4, 2'd2, 8'h00, 8'hBB}, {4'd4, 2'd2, 8'h00, 8'hCC},
    {4'd3, 2'd0, 8'h60, 8'h00}, {4'd3, 2'd1, 8'hC8, 8'h00}, {4'd3, 2'd2, 8'h00, 8'h00},  // R3 clamp
    {4'd1, 2'd0, 8'hFF, 8'h00}, {4'd1, 2'd2, 8'h00, 8'hFF}, {4'd1, 2'd2, 8'h00, 8'h12}   // R1 pointer wrap
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic [7:0] a, input logic w,
                     input logic [7:0] d, input logic r);
    @(negedge clk);
    start_i = s; addr_i = a; wr_i = w; wdata_i = d; rd_i = r;
    @(posedge clk);
    #1;
    start_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    chk({req, " rvalid"}, {7'd0, rvalid_o}, 8'h01);
    chk(req, rdata_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 / R12: reset state
    chk("R11 reset rvalid", {7'd0, rvalid_o}, 8'h00);
    chk("R8 reset pwr", {4'd0, pwr_o}, 8'h00);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] val, exp;
      op = VEC[i][17:16]; val = VEC[i][15:8]; exp = VEC[i][7:0];
      case (op)
        2'd0: cyc(1'b1, val, 1'b0, 8'h00, 1'b0);
        2'd1: cyc(1'b0, 8'h00, 1'b1, val, 1'b0);
        default: rd_chk($sformatf("R%0d vec%0d", VEC[i][21:18], i), exp);
      endcase
    end

    // R8: only the low nibble of 0xF6 written above is kept
    chk("R8 pwr nibble", {4'd0, pwr_o}, 8'h06);

    // R11: idle cycle after a read drops rvalid
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    chk("R11 idle rvalid", {7'd0, rvalid_o}, 8'h00);

    // R9: start and write in the same cycle, then a plain write
    cyc(1'b1, 8'h30, 1'b1, 8'h5E, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 8'h6F, 1'b0);
    cyc(1'b1, 8'h30, 1'b0, 8'h00, 1'b0);
    rd_chk("R9 first", 8'h5E);
    rd_chk("R9 second", 8'h6F);

    // R10: write and read together, write wins, no read response
    cyc(1'b1, 8'h40, 1'b1, 8'h3A, 1'b1);
    chk("R10 rvalid", {7'd0, rvalid_o}, 8'h00);
    cyc(1'b1, 8'h40, 1'b0, 8'h00, 1'b0);
    rd_chk("R10 stored", 8'h3A);

    // R4: scratch index persists across a new transfer
    cyc(1'b1, 8'h60, 1'b1, 8'h05, 1'b0);
    cyc(1'b1, 8'h61, 1'b1, 8'h9D, 1'b0);
    cyc(1'b1, 8'h02, 1'b0, 8'h00, 1'b0);
    cyc(1'b1, 8'h60, 1'b0, 8'h00, 1'b0);
    rd_chk("R4 persist", 8'h06);

    // R12: a mid-run reset clears storage
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 pwr after reset", {4'd0, pwr_o}, 8'h00);
    cyc(1'b1, 8'h02, 1'b0, 8'h00, 1'b0);
    rd_chk("R12 reg cleared", 8'h00);
    cyc(1'b1, 8'h61, 1'b0, 8'h00, 1'b0);
    rd_chk("R12 scratch cleared", 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule